// File: doc/BRIEF.md
# Serial Port Character Buffers with Status Flags

This block holds the characters that wait between a serial port's shift logic and its bus side. It has one buffer for each direction. The shift logic and the bus logic each talk to it through single-cycle push and pop strobes. A mode input chooses the buffer shape at run time. With the mode input high, each direction is a multi-entry FIFO of parameterised depth. With it low, each direction is a single holding register. The full and empty flags always describe whichever buffer shape is in use.

Every received character is stored together with three error tags: framing, parity and break. The framing and parity tags are computed as the character is pushed, from the stop bit, the parity bit and the parity configuration. The tags move through the buffer with their character. The error word always shows the tags of the character at the head of the receive buffer, plus a sticky overrun bit. A one-cycle clear strobe wipes the head's tags and the overrun bit. A ring flag mirrors the active-low ring-indicator modem input.

Top module: `serial_buf_flags`

## Requirements
- R1: After reset, flag_word is 5'b00101 when ring_n is 1: bit0 rx empty = 1, bit1 rx full = 0, bit2 tx empty = 1, bit3 tx full = 0. err_word is 4'b0000.
- R2: With fifo_en low, each buffer holds exactly one character. One accepted push makes that direction full and not empty. Popping the character makes it empty again. The tx empty flag depends only on the buffer.
- R3: With fifo_en high, each buffer holds DEPTH characters. They pop out in push order. The full flag is set only after the DEPTH-th push.
- R4: Flags and read data change at the clock edge that samples the push or pop strobe. A push and a pop in the same cycle on a full buffer are both accepted, and the buffer stays full.
- R5: A pop from an empty buffer leaves the read data at its last value and changes no flag.
- R6: A push into a full buffer is dropped. For the receive side, a dropped push sets err_word bit3 (overrun), which stays set until a clear.
- R7: The framing tag is 1 when rx_stop is 0. With par_en high, the parity tag is 1 when rx_par differs from the expected bit. The expected bit is the XOR of the data for even parity (par_even=1), its inverse for odd parity, and the inverse of par_even when par_stick is 1. The break tag copies rx_brk.
- R8: err_word bits [2:0] are {break, parity, framing} of the character at the head of the receive buffer, and 0 when that buffer is empty.
- R9: A pulse on err_clr zeroes the head character's tags and the overrun bit. An overrun in the same cycle still leaves overrun set. A push into an empty buffer in the same cycle keeps the new character's tags.
- R10: flag_word bit4 is the inverse of ring_n.
- R11: A change of fifo_en empties both buffers at the next edge. Any push or pop in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: multi-entry FIFOs, 0: single holding registers |
| par_en | input | 1 | Parity checking enabled |
| par_even | input | 1 | Even parity select (stuck value select in stick mode) |
| par_stick | input | 1 | Stuck parity mode |
| ring_n | input | 1 | Active-low ring indicator modem input |
| tx_push | input | 1 | Bus side writes a transmit character |
| tx_wdata | input | DW | Transmit character to store |
| tx_pop | input | 1 | Shifter takes the next transmit character |
| tx_rdata | output | DW | Last transmit character popped |
| rx_push | input | 1 | Shifter delivers a received character |
| rx_wdata | input | DW | Received character |
| rx_par | input | 1 | Received parity bit |
| rx_stop | input | 1 | Received stop bit |
| rx_brk | input | 1 | Break detected on this character |
| rx_pop | input | 1 | Bus side reads a received character |
| rx_rdata | output | DW | Last received character popped |
| err_clr | input | 1 | Error clear strobe |
| flag_word | output | 5 | {ring, tx full, tx empty, rx full, rx empty} |
| err_word | output | 4 | {overrun, break, parity, framing} |

## Verification
Two pairs of events can land in one cycle. A push and a pop can arrive together while a buffer is full. An error clear can arrive together with a receive push that either overruns a full buffer or lands in an empty one. The bench drives these coincident strobes on purpose, in both buffer modes. The scoreboard then checks that the surviving characters come out in order, that the full flag stays set, that overrun wins over the clear, and that a freshly pushed head keeps its tags.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
   typedef struct packed {
      logic brk;
      logic pe;
      logic fe;
   } rx_tag_t;

   localparam int TAG_W  = $bits(rx_tag_t);
   localparam int FLAG_W = 5;
   localparam int ERR_W  = TAG_W + 1;
endpackage

// File: rtl/sbuf_rxcheck.sv
module sbuf_rxcheck
   import sbuf_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic [DW-1:0] data,
   input  logic          par_bit,
   input  logic          stop_bit,
   input  logic          brk,
   input  logic          par_en,
   input  logic          par_even,
   input  logic          par_stick,
   output rx_tag_t       tag
);
   logic want;

   always_comb begin
      if (par_stick) want = ~par_even;
      else if (par_even) want = ^data;
      else want = ~(^data);
      tag.fe  = ~stop_bit;
      tag.pe  = par_en & (par_bit ^ want);
      tag.brk = brk;
   end
endmodule

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 32,
   parameter int CLRW  = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         deep,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   input  logic         clr_head,
   output logic [W-1:0] pop_data,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         drop
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("sbuf_fifo: DEPTH must be a power of two of at least 2");
   end
   if (CLRW < 0 || CLRW > W) begin : g_bad_clrw
      $error("sbuf_fifo: CLRW out of range");
   end

   logic [W-1:0]  keep_mask;
   if (CLRW > 0) begin : g_clr
      assign keep_mask = ~((W'(1) << CLRW) - W'(1));
   end else begin : g_noclr
      assign keep_mask = '1;
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt, cap;
   logic          do_push, do_pop;

   assign cap     = deep ? CW'(DEPTH) : CW'(1);
   assign empty   = (cnt == '0);
   assign full    = (cnt == cap);
   assign do_pop  = pop & ~empty & ~flush;
   assign do_push = push & ~flush & (~full | do_pop);
   assign drop    = push & ~flush & full & ~do_pop;
   assign head    = mem[rp];

   always_ff @(posedge clk) begin
      if (clr_head && !empty && !flush) mem[rp] <= mem[rp] & keep_mask;
      if (do_push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp       <= '0;
         rp       <= '0;
         cnt      <= '0;
         pop_data <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop) begin
            rp       <= rp + AW'(1);
            pop_data <= mem[rp];
         end
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   always_comb begin
      if (rst_n) AST_NO_OVERFLOW: assert (cnt <= CW'(DEPTH)); // R3
   end

   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> $stable(cnt)); // R6

   AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> ($stable(pop_data) && empty)); // R5

   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R11
endmodule

// File: rtl/serial_buf_flags.sv
module serial_buf_flags
   import sbuf_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int DW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              par_stick,
   input  logic              ring_n,
   input  logic              tx_push,
   input  logic [DW-1:0]     tx_wdata,
   input  logic              tx_pop,
   output logic [DW-1:0]     tx_rdata,
   input  logic              rx_push,
   input  logic [DW-1:0]     rx_wdata,
   input  logic              rx_par,
   input  logic              rx_stop,
   input  logic              rx_brk,
   input  logic              rx_pop,
   output logic [DW-1:0]     rx_rdata,
   input  logic              err_clr,
   output logic [FLAG_W-1:0] flag_word,
   output logic [ERR_W-1:0]  err_word
);
   localparam int RW = DW + TAG_W;

   if (DW < 5 || DW > 9) begin : g_bad_dw
      $error("serial_buf_flags: DW must be 5 to 9");
   end

   logic          en_q, flush;
   logic          tx_empty, tx_full, tx_drop;
   logic          rx_empty, rx_full, rx_drop;
   logic          ovr;
   logic [DW-1:0] unused_tx_head;
   logic [RW-1:0] rx_head, rx_pop_word;
   rx_tag_t       new_tag, head_tag;

   assign flush = fifo_en ^ en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= fifo_en;
   end

   sbuf_rxcheck #(.DW(DW)) u_chk (
      .data(rx_wdata), .par_bit(rx_par), .stop_bit(rx_stop), .brk(rx_brk),
      .par_en(par_en), .par_even(par_even), .par_stick(par_stick), .tag(new_tag)
   );

   sbuf_fifo #(.W(DW), .DEPTH(DEPTH), .CLRW(0)) u_tx (
      .clk(clk), .rst_n(rst_n), .flush(flush), .deep(fifo_en),
      .push(tx_push), .push_data(tx_wdata), .pop(tx_pop), .clr_head(1'b0),
      .pop_data(tx_rdata), .head(unused_tx_head),
      .empty(tx_empty), .full(tx_full), .drop(tx_drop)
   );

   sbuf_fifo #(.W(RW), .DEPTH(DEPTH), .CLRW(TAG_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .flush(flush), .deep(fifo_en),
      .push(rx_push), .push_data({rx_wdata, new_tag}), .pop(rx_pop), .clr_head(err_clr),
      .pop_data(rx_pop_word), .head(rx_head),
      .empty(rx_empty), .full(rx_full), .drop(rx_drop)
   );

   assign rx_rdata = rx_pop_word[RW-1:TAG_W];
   assign head_tag = rx_empty ? '0 : rx_tag_t'(rx_head[TAG_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr <= 1'b0;
      else if (rx_drop) ovr <= 1'b1;
      else if (err_clr) ovr <= 1'b0;
   end

   assign flag_word = {~ring_n, tx_full, tx_empty, rx_full, rx_empty};
   assign err_word  = {ovr, head_tag};

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_word[3] && !err_clr) |=> err_word[3]); // R6

   AST_CLR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !rx_drop) |=> !err_word[3]); // R9

   AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      tx_drop |-> tx_full); // R6
endmodule

// File: tb/sim_serial_buf_flags.sv
`timescale 1ns/1ps
module sim_serial_buf_flags;
   localparam int DEPTH = 32;

   typedef struct {
      logic [7:0] d;
      logic [2:0] e;
   } item_t;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       fifo_en = 0, par_en = 0, par_even = 0, par_stick = 0, ring_n = 1;
   logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, err_clr = 0;
   logic [7:0] tx_wdata = 0, rx_wdata = 0;
   logic       rx_par = 0, rx_stop = 1, rx_brk = 0;
   logic [7:0] tx_rdata, rx_rdata;
   logic [4:0] flag_word;
   logic [3:0] err_word;

   int     checks = 0, errors = 0, cap = 1;
   bit     done = 0;
   logic   ovr_exp = 0;
   logic [7:0] tx_last = 0, rx_last = 0;
   logic [7:0] txq[$];
   item_t      rxq[$];

   always #2.5 clk = ~clk;

   serial_buf_flags #(.DEPTH(DEPTH), .DW(8)) u0 (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .par_en(par_en), .par_even(par_even),
      .par_stick(par_stick), .ring_n(ring_n), .tx_push(tx_push), .tx_wdata(tx_wdata),
      .tx_pop(tx_pop), .tx_rdata(tx_rdata), .rx_push(rx_push), .rx_wdata(rx_wdata),
      .rx_par(rx_par), .rx_stop(rx_stop), .rx_brk(rx_brk), .rx_pop(rx_pop),
      .rx_rdata(rx_rdata), .err_clr(err_clr), .flag_word(flag_word), .err_word(err_word)
   );

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   function automatic logic [2:0] want_tag(logic [7:0] d, logic p, logic s, logic b);
      logic w;
      if (par_stick) w = ~par_even;
      else if (par_even) w = ^d;
      else w = ~(^d);
      return {b, par_en & (p != w), ~s};
   endfunction

   task automatic check_flags(input string r);
      chk(r, 32'(flag_word), 32'({~ring_n, txq.size() == cap, txq.size() == 0,
                                  rxq.size() == cap, rxq.size() == 0}));
   endtask

   task automatic check_err(input string r);
      chk(r, 32'(err_word), 32'({ovr_exp, (rxq.size() > 0) ? rxq[0].e : 3'b000}));
   endtask

   task automatic push_tx(input logic [7:0] d);
      tx_push = 1; tx_wdata = d;
      tick();
      tx_push = 0;
      if (txq.size() < cap) txq.push_back(d);
   endtask

   task automatic pop_tx(input string r);
      logic [7:0] e;
      e = (txq.size() > 0) ? txq[0] : tx_last;
      tx_pop = 1;
      tick();
      tx_pop = 0;
      chk(r, 32'(tx_rdata), 32'(e));
      if (txq.size() > 0) void'(txq.pop_front());
      tx_last = e;
   endtask

   task automatic push_pop_tx(input string r, input logic [7:0] d);
      logic [7:0] e;
      e = (txq.size() > 0) ? txq[0] : tx_last;
      tx_push = 1; tx_pop = 1; tx_wdata = d;
      tick();
      tx_push = 0; tx_pop = 0;
      chk(r, 32'(tx_rdata), 32'(e));
      if (txq.size() > 0) begin
         void'(txq.pop_front());
         txq.push_back(d);
      end else txq.push_back(d);
      tx_last = e;
   endtask

   task automatic push_rx(input logic [7:0] d, input logic p, input logic s,
                          input logic b, input logic clr);
      item_t it;
      logic  dropped;
      it.d = d; it.e = want_tag(d, p, s, b);
      rx_push = 1; rx_wdata = d; rx_par = p; rx_stop = s; rx_brk = b; err_clr = clr;
      tick();
      rx_push = 0; err_clr = 0; rx_stop = 1; rx_brk = 0;
      dropped = (rxq.size() >= cap);
      if (clr && rxq.size() > 0) rxq[0].e = 3'b000;
      if (!dropped) rxq.push_back(it);
      if (dropped) ovr_exp = 1;
      else if (clr) ovr_exp = 0;
   endtask

   task automatic pop_rx(input string r);
      item_t e;
      check_err({r, " head tags"});
      e.d = (rxq.size() > 0) ? rxq[0].d : rx_last;
      rx_pop = 1;
      tick();
      rx_pop = 0;
      chk({r, " data"}, 32'(rx_rdata), 32'(e.d));
      if (rxq.size() > 0) void'(rxq.pop_front());
      rx_last = e.d;
   endtask

   task automatic clear_err();
      err_clr = 1;
      tick();
      err_clr = 0;
      if (rxq.size() > 0) rxq[0].e = 3'b000;
      ovr_exp = 0;
   endtask

   task automatic switch_mode(input logic m);
      fifo_en = m; tx_push = 1; tx_wdata = 8'hEE; rx_push = 1; rx_wdata = 8'hDD;
      tick();
      tx_push = 0; rx_push = 0;
      txq.delete(); rxq.delete();
      cap = m ? DEPTH : 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 flags", 32'(flag_word), 32'h05);
      chk("R1 err", 32'(err_word), 32'h0);
      // R10 ring flag
      ring_n = 0; #1;
      chk("R10 ring low", 32'(flag_word[4]), 32'h1);
      ring_n = 1; #1;
      chk("R10 ring high", 32'(flag_word[4]), 32'h0);

      // R2 holding register, tx side
      push_tx(8'h41);
      check_flags("R2 tx held");
      push_tx(8'h42);
      check_flags("R6 tx push into full dropped");
      pop_tx("R2 tx pop");
      check_flags("R2 tx empty again");
      pop_tx("R5 pop empty holds data");
      check_flags("R5 pop empty keeps flags");
      push_tx(8'h43);
      push_pop_tx("R4 hold push+pop at full", 8'h44);
      check_flags("R4 hold stays full");
      pop_tx("R4 hold second char");

      // R7, R6, R9 on the receive holding register
      push_rx(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
      check_err("R7 framing tag");
      push_rx(8'h11, 1'b0, 1'b1, 1'b0, 1'b0);
      check_err("R6 overrun set");
      check_flags("R6 rx still full");
      tick();
      check_err("R6 overrun sticky");
      clear_err();
      check_err("R9 clear wipes tags and overrun");
      pop_rx("R8 hold pop");
      check_flags("R2 rx empty");

      // R11 mode change flushes, same-cycle push ignored
      push_tx(8'h10);
      push_rx(8'h20, 1'b0, 1'b1, 1'b0, 1'b0);
      switch_mode(1'b1);
      check_flags("R11 flush to fifo mode");

      // R3 fifo depth and order
      for (int i = 0; i < DEPTH - 1; i++) push_tx(8'(8'h80 + i));
      check_flags("R3 one below full");
      push_tx(8'hC0);
      check_flags("R3 full at depth");
      push_tx(8'hC1);
      check_flags("R6 fifo push into full dropped");
      push_pop_tx("R4 fifo push+pop at full", 8'hC2);
      check_flags("R4 fifo stays full");
      while (txq.size() > 0) pop_tx("R3 fifo order");
      check_flags("R3 fifo drained");

      // R7 and R8: tags per character with various parity settings
      par_en = 1; par_even = 1; par_stick = 0;
      push_rx(8'h03, 1'b0, 1'b1, 1'b0, 1'b0);
      push_rx(8'h07, 1'b0, 1'b1, 1'b0, 1'b0);
      par_even = 0;
      push_rx(8'h07, 1'b0, 1'b1, 1'b0, 1'b0);
      push_rx(8'h01, 1'b1, 1'b1, 1'b0, 1'b0);
      par_stick = 1; par_even = 1;
      push_rx(8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
      par_even = 0;
      push_rx(8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
      push_rx(8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
      check_flags("R3 rx partially filled");
      while (rxq.size() > 0) pop_rx("R7 R8 head tag order");
      check_err("R8 empty shows no tags");

      // R9 clear together with push into empty keeps new tags
      par_en = 0; par_stick = 0;
      push_rx(8'h33, 1'b0, 1'b0, 1'b1, 1'b1);
      check_err("R9 push into empty with clear");
      for (int i = 1; i < DEPTH; i++) push_rx(8'(i), 1'b0, 1'b1, 1'b0, 1'b0);
      check_flags("R3 rx full");
      push_rx(8'hFF, 1'b0, 1'b0, 1'b0, 1'b1);
      check_err("R9 overrun wins over clear");
      rx_pop = 1; err_clr = 0; tick(); rx_pop = 0;
      chk("R4 rx pop data", 32'(rx_rdata), 32'(rxq[0].d));
      rx_last = rxq[0].d; void'(rxq.pop_front());
      check_flags("R4 rx one below full");

      // R11 flush back to holding mode mid-traffic
      switch_mode(1'b0);
      check_flags("R11 flush to hold mode");
      chk("R11 overrun kept across flush", 32'(err_word[3]), 32'(ovr_exp));
      pop_rx("R5 rx pop after flush");
      check_flags("R5 rx pop empty keeps flags");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule